// File: doc/BRIEF.md
# No-Wait Pipelined Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that never needs an idle cycle when the bus turns from reads to writes or back. Every command, address, byte-enable and data input is sampled on the rising edge of one clock. Read data is returned through an output register. Write data is taken late, at the same pipeline depth as read data, so a stream of mixed reads and writes can occupy the bus on every cycle. An active-low clock enable freezes the whole pipeline.

A cycle with the advance input low starts a new access from the external address. That access is a read, a write or a deselect. A cycle with advance high continues the current access at the next address of a four-beat burst. The burst order is interleaved or linear, as chosen by a mode pin. Writes are held in a one-entry late-write buffer and committed to the array when the next write arrives. Reads that hit the buffered word are served from it byte by byte.

Top module: `nowait_sram`

## Requirements
- R1: A read command sampled on an enabled edge drives `rdata` with the word at its address and raises `oe` after the second enabled edge that follows it.
- R2: While `cen_n` is HIGH, all other inputs are ignored. The array, the burst state, the pipeline, `rdata` and `oe` hold their values, and an access in flight finishes after the same number of enabled edges as without the stall.
- R3: With `adv` LOW and `cs_n` LOW, the external address is loaded and a new access begins. It is a write if `we_n` is LOW and a read if `we_n` is HIGH.
- R4: With `adv` LOW and `cs_n` HIGH, the device is deselected. That access's data phase has `oe` LOW and changes no word, and following cycles with `adv` HIGH stay deselected.
- R5: With `adv` HIGH, the access type in progress continues. The address bits above the two lowest stay at the loaded value, and the 2-bit beat count increases by one, so the fifth beat returns to the start address.
- R6: With `mode` HIGH, the two lowest address bits of a beat are the loaded start bits XOR the beat count (0 for the loaded beat).
- R7: With `mode` LOW, the two lowest address bits of a beat are (start + beat count) mod 4.
- R8: Write data is sampled from `wdata` on the second enabled edge after its write command. A word is four 9-bit bytes, byte b being bits 9b+8 down to 9b. `bw_n[b]` is sampled with the command and is active low, and unselected bytes keep their old contents.
- R9: A read may follow a write on the next cycle and a write may follow a read on the next cycle. A read always returns the most recently written bytes of its word, including a write still held in the late-write buffer.
- R10: A synchronous active-high `rst` empties the pipeline, deselects the burst state and clears `oe`. Writes whose data was already taken before reset are kept, and commands still in the pipeline are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; HIGH freezes everything |
| adv | input | 1 | HIGH: next burst beat; LOW: load a new address |
| cs_n | input | 1 | Chip select, active low, sampled when a new address is loaded |
| we_n | input | 1 | Write command, active low; HIGH means read |
| mode | input | 1 | Burst order: HIGH interleaved, LOW linear |
| bw_n | input | 4 | Byte write enables, active low, one per 9-bit byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 36 | Write data, sampled two enabled edges after its command |
| rdata | output | 36 | Registered read data |
| oe | output | 1 | HIGH while `rdata` carries read data |

## Verification
The assertions check on every cycle that `oe` follows the read or non-read type of the command at the end of the pipeline, and that a stall freezes `rdata` and `oe`. They also check that the upper address bits stay fixed across enabled burst beats, and that a read hitting a fully enabled buffered write returns that write's data. Some behaviour appears only across whole sequences, and only the bench's scenarios show it. This covers the exact interleaved and linear beat orders with wrap, partial byte merges against older contents, back-to-back same-address write and read pairs, junk inputs ignored during a stall, deselected bursts leaving memory untouched, and the fate of in-flight writes across a reset. The bench shows this by sweeping every address, every start offset in both orders and every byte-enable pattern against an arithmetic model.

// File: rtl/nowait_sram_pkg.sv
package nowait_sram_pkg;

    localparam int BYTE_W  = 9;
    localparam int NBYTES  = 4;
    localparam int WORD_W  = BYTE_W * NBYTES;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits of a burst beat
    function automatic logic [BURST_W-1:0] burst_lsb(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

    function automatic op_e decode_op(input logic cs_n, input logic we_n);
        if (cs_n)      return OP_IDLE;
        else if (we_n) return OP_READ;
        else           return OP_WRITE;
    endfunction

    // Replace the bytes selected by ben
    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [NBYTES-1:0] ben
    );
        logic [WORD_W-1:0] res;
        for (int b = 0; b < NBYTES; b++) begin
            res[b*BYTE_W +: BYTE_W] = ben[b] ? new_w[b*BYTE_W +: BYTE_W]
                                             : old_w[b*BYTE_W +: BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/nowait_sram_burst.sv
module nowait_sram_burst
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                adv,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                mode,
    input  logic [NBYTES-1:0]   bw_n,
    input  logic [ADDR_W-1:0]   addr,
    output op_e                 cmd_op,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [NBYTES-1:0]   cmd_ben
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] beat_nxt;
    op_e                op_q;

    assign beat_nxt = beat_q + BURST_W'(1);

    always_comb begin
        if (!adv) begin
            cmd_op   = decode_op(cs_n, we_n);
            cmd_addr = addr;
        end else begin
            cmd_op   = op_q;
            cmd_addr = {hi_q, burst_lsb(start_q, beat_nxt, mode)};
        end
        cmd_ben = (cmd_op == OP_WRITE) ? ~bw_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q    <= OP_IDLE;
            hi_q    <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (en) begin
            if (!adv) begin
                op_q    <= cmd_op;
                hi_q    <= addr[ADDR_W-1:BURST_W];
                start_q <= addr[BURST_W-1:0];
                beat_q  <= '0;
            end else begin
                beat_q  <= beat_nxt;
            end
        end
    end

    // R5: upper address bits do not move across consecutive enabled beats
    p_hi_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        (en && adv && $past(en) && op_q != OP_IDLE)
        |-> cmd_addr[ADDR_W-1:BURST_W] == $past(cmd_addr[ADDR_W-1:BURST_W]));

endmodule

// File: rtl/nowait_sram_store.sv
module nowait_sram_store
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  op_e                 op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NBYTES-1:0]   ben,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                oe
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // One-entry late-write buffer
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;
    logic [WORD_W-1:0] pend_data;
    logic [NBYTES-1:0] pend_ben;

    logic              hit;
    logic [WORD_W-1:0] rd_word;
    logic              commit;

    assign hit     = pend_v && (pend_addr == addr);
    assign rd_word = merge_bytes(mem[addr], pend_data, hit ? pend_ben : '0);
    assign commit  = pend_v && (rst || (en && op == OP_WRITE));

    always_ff @(posedge clk) begin
        if (commit) begin
            mem[pend_addr] <= merge_bytes(mem[pend_addr], pend_data, pend_ben);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
            pend_ben  <= '0;
            rdata     <= '0;
            oe        <= 1'b0;
        end else if (en) begin
            oe <= (op == OP_READ);
            if (op == OP_READ) begin
                rdata <= rd_word;
            end
            if (op == OP_WRITE) begin
                pend_v    <= 1'b1;
                pend_addr <= addr;
                pend_data <= wdata;
                pend_ben  <= ben;
            end
        end
    end

    // R2: a stalled cycle leaves the output register untouched
    p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(rdata) && $stable(oe)));

    // R9: a read that hits a fully enabled buffered write returns its data
    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (en && op == OP_READ && pend_v && pend_addr == addr && pend_ben == '1)
        |=> rdata == $past(pend_data));

endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
    import nowait_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cen_n,
    input  logic                adv,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                mode,
    input  logic [NBYTES-1:0]   bw_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic                oe
);

    logic en;
    assign en = ~cen_n;

    op_e               cmd_op, s1_op, s2_op;
    logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
    logic [NBYTES-1:0] cmd_ben, s1_ben, s2_ben;

    nowait_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .adv      (adv),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .mode     (mode),
        .bw_n     (bw_n),
        .addr     (addr),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_ben  (cmd_ben)
    );

    // Two command stages: data phase lands two enabled edges after address
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_ben  <= '0;
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_ben  <= '0;
        end else if (en) begin
            s1_op   <= cmd_op;
            s1_addr <= cmd_addr;
            s1_ben  <= cmd_ben;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_ben  <= s1_ben;
        end
    end

    nowait_sram_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .op    (s2_op),
        .addr  (s2_addr),
        .ben   (s2_ben),
        .wdata (wdata),
        .rdata (rdata),
        .oe    (oe)
    );

    // R1: a read reaching the data phase drives oe on the next edge
    p_read_oe_r1: assert property (@(posedge clk) disable iff (rst)
        (en && s2_op == OP_READ) |=> oe);

    // R4: a deselected data phase keeps oe low
    p_desel_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (en && s2_op == OP_IDLE) |=> !oe);

    // R8: writes never drive read data out
    p_write_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (en && s2_op == OP_WRITE) |=> !oe);

endmodule

// File: tb/nowait_sram_tb.sv
module nowait_sram_tb;
    import nowait_sram_pkg::*;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst, cen_n, adv, cs_n, we_n, mode;
    logic [3:0]        bw_n;
    logic [AW-1:0]     addr;
    logic [35:0]       wdata, rdata;
    logic              oe;

    always #10 clk = ~clk;

    nowait_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .adv(adv), .cs_n(cs_n),
        .we_n(we_n), .mode(mode), .bw_n(bw_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .oe(oe)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int seq    = 0;

    logic [35:0] ref_mem [DEPTH];

    // bench model of the burst state and the two command stages
    op_e           b_op;
    logic [AW-3:0] b_hi;
    logic [1:0]    b_st, b_cnt;
    op_e           p1_op, p2_op;
    logic [AW-1:0] p1_a, p2_a;
    logic [3:0]    p1_be, p2_be;
    string         p1_t, p2_t;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [35:0] mkdata(input int s);
        return {9'(s * 7 + 1), 9'(s * 13 + 2), 9'(s * 3 + 5), 9'(s + 9)};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one enabled cycle; called at a falling edge, returns at the next one
    task automatic cyc(input logic a_adv, input logic a_cs_n, input logic a_we_n,
                       input logic a_mode, input logic [3:0] a_bw_n,
                       input logic [AW-1:0] a_addr, input string tag);
        op_e           nop;
        logic [AW-1:0] na;
        logic [3:0]    nbe;
        logic [35:0]   wd;
        logic [1:0]    lo;
        if (!a_adv) begin
            nop   = a_cs_n ? OP_IDLE : (a_we_n ? OP_READ : OP_WRITE);
            na    = a_addr;
            b_op  = nop;
            b_hi  = a_addr[AW-1:2];
            b_st  = a_addr[1:0];
            b_cnt = 2'd0;
        end else begin
            b_cnt = b_cnt + 2'd1;
            nop   = b_op;
            lo    = a_mode ? (b_st ^ b_cnt) : 2'(b_st + b_cnt);
            na    = {b_hi, lo};
        end
        nbe = (nop == OP_WRITE) ? ~a_bw_n : 4'h0;
        if (p2_op == OP_WRITE) begin
            wd = mkdata(seq);
            seq++;
        end else begin
            wd = 36'hA5A5A5A5A;
        end
        cen_n = 1'b0; adv = a_adv; cs_n = a_cs_n; we_n = a_we_n;
        mode = a_mode; bw_n = a_bw_n; addr = a_addr; wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (p2_op == OP_READ) begin
            chk(p2_t, {35'b0, oe}, 36'd1);
            chk(p2_t, rdata, ref_mem[p2_a]);
        end else begin
            chk(p2_t, {35'b0, oe}, 36'd0);
        end
        if (p2_op == OP_WRITE) begin
            for (int b = 0; b < 4; b++) begin
                if (p2_be[b]) ref_mem[p2_a][b*9 +: 9] = wd[b*9 +: 9];
            end
        end
        p2_op = p1_op; p2_a = p1_a; p2_be = p1_be; p2_t = p1_t;
        p1_op = nop;   p1_a = na;   p1_be = nbe;   p1_t = tag;
    endtask

    task automatic idle_cyc(input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'hF, '0, tag);
    endtask

    // stalled cycle with junk that would write if it were not ignored (R2)
    task automatic stall(input logic [AW-1:0] junk_a);
        logic [35:0] r0;
        logic        o0;
        r0 = rdata; o0 = oe;
        cen_n = 1'b1; adv = 1'b0; cs_n = 1'b0; we_n = 1'b0;
        bw_n = 4'h0; addr = junk_a; wdata = 36'h123456789;
        @(posedge clk);
        @(negedge clk);
        chk("R2", {35'b0, oe}, {35'b0, o0});
        chk("R2", rdata, r0);
    endtask

    task automatic do_reset();
        rst = 1'b1; cen_n = 1'b0; adv = 1'b0; cs_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10", {35'b0, oe}, 36'd0);
        p1_op = OP_IDLE; p2_op = OP_IDLE; b_op = OP_IDLE;
        p1_t = "R10"; p2_t = "R10"; p1_be = '0; p2_be = '0; p1_a = '0; p2_a = '0;
    endtask

    initial begin
        rst = 1'b1; cen_n = 1'b0; adv = 1'b0; cs_n = 1'b1; we_n = 1'b1;
        mode = 1'b0; bw_n = 4'hF; addr = '0; wdata = '0;
        b_hi = '0; b_st = '0; b_cnt = '0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        @(negedge clk);
        do_reset();
        idle_cyc("R10");
        idle_cyc("R10");

        // R3 / R8: write every word, then R1: read every word back
        for (int a = 0; a < DEPTH; a++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, AW'(a), "R3");
        for (int a = 0; a < DEPTH; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R1");

        // R5 / R6 / R7: read bursts from every start, both orders, with wrap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1'b0, 1'b0, 1'b1, m[0], 4'hF, AW'(20 + s), m ? "R6" : "R7");
                for (int k = 1; k < 4; k++) cyc(1'b1, 1'b0, 1'b1, m[0], 4'hF, '0, m ? "R6" : "R7");
                cyc(1'b1, 1'b0, 1'b1, m[0], 4'hF, '0, "R5");
            end
        end
        // R5: write bursts in both orders, verified by the read sweep below
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1'b0, 1'b0, 1'b0, m[0], 4'h0, AW'(24 + 4 * m + s), "R5");
                for (int k = 1; k < 4; k++) cyc(1'b1, 1'b1, 1'b1, m[0], 4'(k), '0, "R5");
            end
        end
        for (int a = 24; a < 32; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R5");

        // R8: every byte-enable pattern against older contents
        for (int be = 0; be < 16; be++) cyc(1'b0, 1'b0, 1'b0, 1'b0, ~4'(be), AW'(32 + be), "R8");
        for (int a = 32; a < 48; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R8");

        // R9: back-to-back write/read and read/write on the same word
        for (int a = 48; a < 56; a++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, AW'(a), "R9");
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R9");
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'(a & 5), AW'(a), "R9");
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R9");
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'hA, AW'(a), "R9");
        end
        for (int a = 48; a < 56; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R9");

        // R4: deselected burst with write strobes asserted
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, AW'(8), "R4");
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, AW'(9 + k), "R4");
        for (int a = 8; a < 12; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R4");

        // R2: stalls in the middle of a mixed stream
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(5), "R2");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, AW'(6), "R2");
        stall(AW'(2));
        stall(AW'(3));
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(6), "R2");
        stall(AW'(4));
        for (int a = 0; a < 8; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(a), "R2");

        // R10: reset with writes in flight
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, AW'(60), "R10");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, AW'(61), "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(60), "R10");
        do_reset();
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 4'h0, '0, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(60), "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(61), "R10");
        idle_cyc("R10");
        idle_cyc("R10");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule